// File: doc/BRIEF.md
# Reference-Edge to Signal-Transition Delay Timer

This block measures how long a selected test signal takes to change after a rising edge of a slow reference clock. The delay is counted in cycles of the fast system clock. The same reference clock also drives the device under test. A rising reference edge opens a counting window. The first transition of the chosen test line, in either direction, closes the window, and the count is kept as one sample.

A run is started with a command. The run takes the requested number of samples from the line picked by a select index, keeps the most recent result, and tracks the smallest and largest valid results. A sample whose line does not move before the next reference edge is marked as a timeout. Timed-out samples stay out of the extremes. When the run completes, a level done flag goes high. A host steps through the candidate lines by issuing one run per line.

Top module: `edge_delay_timer`

## Requirements
- R1: After reset, done is 0, last_count is 0, last_timeout is 0, min_count is all ones and max_count is 0.
- R2: When the reference input is sampled high at fast-clock edge P (after being low) and the selected line is first sampled changed at edge P+d, the reported last_count is d.
- R3: Only sig_in[sel] can close the window. Transitions on the other lines do not change the result.
- R4: The select index is captured when start is accepted. Changing sel during a run has no effect on that run.
- R5: min_count and max_count hold the smallest and largest non-timeout results of the run. When start is accepted they return to all ones and zero.
- R6: If the selected line does not change before the next reference rising edge, the sample reports last_count all ones and last_timeout 1, and it leaves min_count and max_count unchanged.
- R7: If neither a transition nor a reference edge arrives, the window closes once the count would reach all-ones minus one. That sample is a timeout, reported as in R6.
- R8: done rises after num_samples samples have been taken (a value of 0 counts as 1). It stays high until a new start is accepted, which clears it. start is accepted only while idle or done.
- R9: A transition of the selected line that occurs while the block waits for the reference edge does not close a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timebase; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock whose rising edge opens the window |
| sig_in | input | NUM_SIG | Candidate test lines |
| sel | input | SEL_W | Index of the line to time, captured at start |
| start | input | 1 | Begins a run while idle or done |
| num_samples | input | SAMP_W | Number of samples per run (0 treated as 1) |
| last_count | output | CNT_W | Most recent sample result |
| last_timeout | output | 1 | Most recent sample was a timeout |
| min_count | output | CNT_W | Smallest valid result of the run |
| max_count | output | CNT_W | Largest valid result of the run |
| done | output | 1 | Run complete |

## Verification
Faults in the counter or in the window control appear as a wrong last_count three cycles after the closing transition is sampled. The shift is by a constant for a pipeline error and by zero or all ones for a lost edge. A select register that follows sel during a run, or a timeout that leaks into the extremes, changes min_count or max_count at that same latch cycle. A sample counter that is off by one moves the rise of done by a whole reference period, which the mid-run checks of done catch.

// File: rtl/edt_pkg.sv
package edt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_COUNT,
      ST_LATCH,
      ST_DONE
   } edt_state_e;
endpackage

// File: rtl/edt_sync.sv
module edt_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("edt_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/edt_edges.sv
module edt_edges #(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_s,
   input  logic [N-1:0]     sig_s,
   input  logic [SEL_W-1:0] sel_q,
   output logic             ref_rise,
   output logic             sig_edge
);
   logic sig_now, sig_prev, ref_prev;

   generate
      if ((1 << SEL_W) == N) begin : g_full_mux
         assign sig_now = sig_s[sel_q];
      end else begin : g_guard_mux
         always_comb begin
            sig_now = 1'b0;
            for (int i = 0; i < N; i++)
               if (sel_q == SEL_W'(i)) sig_now = sig_s[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_prev <= 1'b0;
         sig_prev <= 1'b0;
      end else begin
         ref_prev <= ref_s;
         sig_prev <= sig_now;
      end
   end

   assign ref_rise = ref_s & ~ref_prev;
   assign sig_edge = sig_now ^ sig_prev;
endmodule

// File: rtl/edt_seq.sv
module edt_seq
   import edt_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int SAMP_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ref_rise,
   input  logic              sig_edge,
   input  logic [SEL_W-1:0]  sel,
   input  logic [SAMP_W-1:0] num_samples,
   output logic [SEL_W-1:0]  sel_q,
   output logic              clr,
   output logic              cap_valid,
   output logic [CNT_W-1:0]  cap_count,
   output logic              cap_timeout,
   output logic              done
);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

   edt_state_e        st;
   logic [CNT_W-1:0]  cnt, cnt_nx;
   logic [SAMP_W-1:0] n_q;
   logic [SAMP_W:0]   taken, taken_nx;

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("edt_seq: CNT_W must be at least 3");
      end
   endgenerate

   assign cnt_nx    = cnt + 1'b1;
   assign taken_nx  = taken + 1'b1;
   assign clr       = (st == ST_IDLE || st == ST_DONE) && start;
   assign cap_valid = (st == ST_LATCH);
   assign done      = (st == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cnt         <= '0;
         sel_q       <= '0;
         n_q         <= '0;
         taken       <= '0;
         cap_count   <= '0;
         cap_timeout <= 1'b0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  st    <= ST_ARM;
                  sel_q <= sel;
                  n_q   <= num_samples;
                  taken <= '0;
               end
            end
            ST_ARM: begin
               if (ref_rise) begin
                  st  <= ST_COUNT;
                  cnt <= '0;
               end
            end
            ST_COUNT: begin
               if (sig_edge) begin
                  cap_count   <= cnt_nx;
                  cap_timeout <= 1'b0;
                  st          <= ST_LATCH;
               end else if (ref_rise || cnt_nx == CNT_LAST) begin
                  cap_count   <= CNT_MAX;
                  cap_timeout <= 1'b1;
                  st          <= ST_LATCH;
               end else begin
                  cnt <= cnt_nx;
               end
            end
            ST_LATCH: begin
               taken <= taken_nx;
               st    <= (taken_nx >= {1'b0, n_q}) ? ST_DONE : ST_ARM;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COUNT || st == ST_LATCH) |-> $stable(sel_q));

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COUNT && $past(st) == ST_COUNT) |-> (cnt == $past(cnt) + 1'b1));

   // R8
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);

   // R8
   done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(st) == ST_LATCH));
endmodule

// File: rtl/edt_stats.sv
module edt_stats #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cap_valid,
   input  logic [CNT_W-1:0] cap_count,
   input  logic             cap_timeout,
   output logic [CNT_W-1:0] last_count,
   output logic             last_timeout,
   output logic [CNT_W-1:0] min_count,
   output logic [CNT_W-1:0] max_count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_count   <= '0;
         last_timeout <= 1'b0;
         min_count    <= '1;
         max_count    <= '0;
      end else if (clr) begin
         min_count <= '1;
         max_count <= '0;
      end else if (cap_valid) begin
         last_count   <= cap_count;
         last_timeout <= cap_timeout;
         if (!cap_timeout) begin
            if (cap_count < min_count) min_count <= cap_count;
            if (cap_count > max_count) max_count <= cap_count;
         end
      end
   end

   // R5
   min_max_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (max_count != '0) |-> (min_count <= max_count));

   // R6
   timeout_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && cap_timeout && !clr) |=> ($stable(min_count) && $stable(max_count)));
endmodule

// File: rtl/edge_delay_timer.sv
module edge_delay_timer #(
   parameter int  NUM_SIG     = 4,
   parameter int  CNT_W       = 12,
   parameter int  SAMP_W      = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int SEL_W       = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk,
   input  logic [NUM_SIG-1:0] sig_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic              start,
   input  logic [SAMP_W-1:0] num_samples,
   output logic [CNT_W-1:0]  last_count,
   output logic              last_timeout,
   output logic [CNT_W-1:0]  min_count,
   output logic [CNT_W-1:0]  max_count,
   output logic              done
);
   localparam int SYNC_W = NUM_SIG + 1;

   logic [SYNC_W-1:0] raw_bus, sync_bus;
   logic [SEL_W-1:0]  sel_q;
   logic              ref_rise, sig_edge, clr, cap_valid, cap_timeout;
   logic [CNT_W-1:0]  cap_count;

   generate
      if (NUM_SIG < 1) begin : g_bad_num
         $error("edge_delay_timer: NUM_SIG must be at least 1");
      end
   endgenerate

   assign raw_bus = {ref_clk, sig_in};

   edt_sync #(.STAGES(SYNC_STAGES), .W(SYNC_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
   );

   edt_edges #(.N(NUM_SIG), .SEL_W(SEL_W)) u_edges (
      .clk(clk), .rst_n(rst_n),
      .ref_s(sync_bus[NUM_SIG]), .sig_s(sync_bus[NUM_SIG-1:0]), .sel_q(sel_q),
      .ref_rise(ref_rise), .sig_edge(sig_edge)
   );

   edt_seq #(.CNT_W(CNT_W), .SAMP_W(SAMP_W), .SEL_W(SEL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_rise(ref_rise),
      .sig_edge(sig_edge), .sel(sel), .num_samples(num_samples),
      .sel_q(sel_q), .clr(clr), .cap_valid(cap_valid), .cap_count(cap_count),
      .cap_timeout(cap_timeout), .done(done)
   );

   edt_stats #(.CNT_W(CNT_W)) u_stats (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cap_valid(cap_valid),
      .cap_count(cap_count), .cap_timeout(cap_timeout),
      .last_count(last_count), .last_timeout(last_timeout),
      .min_count(min_count), .max_count(max_count)
   );
endmodule

// File: tb/edge_delay_timer_test.sv
module edge_delay_timer_test;
   localparam int CW  = 12;
   localparam int ALL = (1 << CW) - 1;
   localparam int PER = 40;
   localparam int VN  = 6;
   localparam int VSEL [VN] = '{0, 1, 2, 3, 1, 0};
   localparam int VDLY [VN] = '{5, 1, 17, 9, 12, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_clk = 1'b0;
   logic [3:0]    sig = 4'b0;
   logic [1:0]    sel = 2'd0;
   logic          start = 1'b0;
   logic [7:0]    num = 8'd1;
   logic [CW-1:0] last_count, min_count, max_count;
   logic          last_timeout, done;
   int checks = 0;
   int errors = 0;

   edge_delay_timer uut (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .sig_in(sig), .sel(sel),
      .start(start), .num_samples(num), .last_count(last_count),
      .last_timeout(last_timeout), .min_count(min_count),
      .max_count(max_count), .done(done)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic begin_run(input int s, input int n);
      @(negedge clk);
      sel = 2'(s); num = 8'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // One reference period; tgt/dis < 0 means that line stays still
   task automatic period(input int tgt, input int d, input int dis, input int dd);
      @(negedge clk);
      ref_clk = 1'b1;
      for (int k = 1; k < PER; k++) begin
         @(negedge clk);
         if (tgt >= 0 && k == d) sig[tgt] = ~sig[tgt];
         if (dis >= 0 && k == dd) sig[dis] = ~sig[dis];
         if (k == PER / 2) ref_clk = 1'b0;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", done, 0);
      chk("R1 last_count", last_count, 0);
      chk("R1 last_timeout", last_timeout, 0);
      chk("R1 min_count", min_count, ALL);
      chk("R1 max_count", max_count, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2/R3 vector table, distractor line toggled one cycle before target
      for (int v = 0; v < VN; v++) begin
         begin_run(VSEL[v], 1);
         period(VSEL[v], VDLY[v], (VSEL[v] + 1) % 4, VDLY[v] - 1);
         chk("R2 vector count", last_count, VDLY[v]);
         chk("R3 vector timeout flag", last_timeout, 0);
         chk("R8 vector done", done, 1);
      end

      // R4 sel changed mid-run; target line 2 at 7, new sel line 0 at 4
      begin_run(2, 1);
      sel = 2'd0;
      period(2, 7, 0, 4);
      chk("R4 latched select", last_count, 7);

      // R9 selected line moves while armed, before reference edge
      begin_run(1, 1);
      sig[1] = ~sig[1];
      repeat (3) @(negedge clk);
      period(1, 6, -1, 0);
      chk("R9 armed transition ignored", last_count, 6);

      // R5/R8 multi-sample run, start clears done and extremes
      begin_run(3, 3);
      chk("R8 start clears done", done, 0);
      chk("R5 min cleared", min_count, ALL);
      chk("R5 max cleared", max_count, 0);
      period(3, 8, -1, 0);
      period(3, 14, -1, 0);
      chk("R8 not done after 2 of 3", done, 0);
      period(3, 4, -1, 0);
      chk("R8 done after 3", done, 1);
      chk("R5 last", last_count, 4);
      chk("R5 min", min_count, 4);
      chk("R5 max", max_count, 14);

      // R6 second sample sees no transition before next reference edge
      begin_run(0, 2);
      period(0, 10, -1, 0);
      period(-1, 0, -1, 0);
      period(-1, 0, -1, 0);
      chk("R6 timeout count", last_count, ALL);
      chk("R6 timeout flag", last_timeout, 1);
      chk("R6 min excludes timeout", min_count, 10);
      chk("R6 max excludes timeout", max_count, 10);
      chk("R6 done", done, 1);

      // R8 zero samples treated as one
      begin_run(1, 0);
      period(1, 3, -1, 0);
      chk("R8 zero-count done", done, 1);
      chk("R8 zero-count result", last_count, 3);

      // R7 saturation with reference held high
      begin_run(2, 1);
      @(negedge clk);
      ref_clk = 1'b1;
      repeat (4200) @(negedge clk);
      chk("R7 saturated count", last_count, ALL);
      chk("R7 saturated flag", last_timeout, 1);
      chk("R7 min untouched", min_count, ALL);
      chk("R7 max untouched", max_count, 0);
      chk("R7 done", done, 1);
      ref_clk = 1'b0;
      repeat (4) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule